// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general-purpose register store of a 32-bit processor that runs in seven operating modes. Software names sixteen registers, r0 to r15. The physical entry behind a name depends on the current mode. Each exception mode keeps private copies of some registers, so a handler can run without saving the interrupted code's stack pointer and return link. The fast-interrupt mode has the largest private set (r8 to r14). This lets a fast handler use a set of working registers without saving anything first.

The block holds the current mode in a register. It offers two combinational read ports and one write port, each addressed by a 4-bit register number. It also holds a saved-status register for each of the five exception modes, with its own read and write port. A user-bank override input lets privileged code reach the user registers, so that it can save or restore them. The program counter r15 is stored like any other shared entry. The block decodes no instructions and does no exception sequencing; its surrounding pipeline does that.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous active-low reset, the current mode is supervisor (10011). Every register reads zero in every mode, and every saved-status register reads zero.
- R2: When `mode_ld` is high at a rising edge, `mode_in` becomes the current mode from that edge on. The mode encodings are: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.
- R3: r0 to r7 and r15 select the same physical entries in every mode.
- R4: In fast-interrupt mode, r8 to r14 select entries private to that mode.
- R5: Interrupt, supervisor, abort and undefined modes each have their own r13 and r14. These modes share r8 to r12 with user mode.
- R6: System mode selects exactly the user registers and has no saved-status register.
- R7: A mode value outside the seven encodings selects the user registers and has no saved-status register.
- R8: Each of the five exception modes has its own saved-status register. `sts_rd_data` shows the register of the current mode, and `sts_wr_en` writes that register at the edge.
- R9: In user, system or an unlisted mode, `sts_rd_data` reads zero and a write to the saved-status register changes no saved-status register.
- R10: While `user_bank` is high, all three register ports select user registers whatever the current mode. The saved-status port still follows the current mode.
- R11: A write takes effect at the rising edge. A read of the register being written in that cycle returns the old value. A register write in the same cycle as a mode load uses the old mode.
- R12: The two read ports are independent. Each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_ld | input | 1 | Load `mode_in` into the current mode |
| mode_in | input | 5 | New mode value |
| cur_mode | output | 5 | Current mode |
| user_bank | input | 1 | Force register ports to the user registers |
| rd_a_sel | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| sts_wr_en | input | 1 | Saved-status write enable |
| sts_wr_data | input | 32 | Saved-status write data |
| sts_rd_data | output | 32 | Saved-status of the current mode |

## Verification
The read ports and `sts_rd_data` are combinational. A change of select, override or current mode shows on them within the same cycle. Register writes, saved-status writes and mode loads show from the first rising edge after they are presented. The bench drives all inputs on the falling edge and compares the outputs 5 ns later against a bench model. That model still holds the state from before the next rising edge, so a same-cycle read is expected to return the old value. The model then applies the presented writes and mode load at the rising edge, using the old mode for the register writes.

// File: rtl/bank_pkg.sv
// Shared encodings and physical layout of the mode-banked register file.
// Assumes a 16-entry architectural register space and seven operating modes.
package bank_pkg;
    localparam int MODE_W = 5;
    localparam int REG_W  = 4;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    // Register bank selected by a mode; USR also serves system and unlisted modes
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int NUM_BANKS    = 6;
    localparam int NUM_SAVED    = NUM_BANKS - 1;
    localparam int NUM_LOW      = 8;   // r0..r7, never banked
    localparam int HI_FIRST     = 8;   // r8
    localparam int NUM_HI       = 5;   // r8..r12
    localparam int SPLR_FIRST   = HI_FIRST + NUM_HI;   // r13
    localparam int NUM_SPLR     = 2;   // r13, r14
    localparam int PC_NUM       = 15;

    // Physical layout: low | user hi | fiq hi | sp/lr per bank | pc
    localparam int PHYS_HI_USR  = NUM_LOW;
    localparam int PHYS_HI_FIQ  = PHYS_HI_USR + NUM_HI;
    localparam int PHYS_SPLR    = PHYS_HI_FIQ + NUM_HI;
    localparam int PHYS_PC      = PHYS_SPLR + NUM_SPLR * NUM_BANKS;
    localparam int NUM_PHYS     = PHYS_PC + 1;
    localparam int PHYS_IDX_W   = $clog2(NUM_PHYS);
endpackage

// File: rtl/mode_decode.sv
// Mode decoder: turns a 5-bit mode value into a register bank and a flag
// telling whether the mode owns a saved-status register.
// Assumes unlisted mode values behave as user mode.
module mode_decode
    import bank_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              has_saved
);
    // Map each legal encoding to its bank; default to the user bank
    always_comb begin
        bank      = BK_USR;
        has_saved = 1'b1;
        case (mode)
            MODE_FIQ: bank = BK_FIQ;
            MODE_IRQ: bank = BK_IRQ;
            MODE_SVC: bank = BK_SVC;
            MODE_ABT: bank = BK_ABT;
            MODE_UND: bank = BK_UND;
            default: begin
                bank      = BK_USR;
                has_saved = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/phys_map.sv
// Register-number to physical-entry mapper for one port.
// Assumes the layout in bank_pkg; r15 and r0..r7 ignore the bank.
module phys_map
    import bank_pkg::*;
(
    input  logic [REG_W-1:0]      reg_num,
    input  bank_e                 bank,
    output logic [PHYS_IDX_W-1:0] idx
);
    int off;

    // Pick the physical slot from the register group and the bank
    always_comb begin
        if (int'(reg_num) < NUM_LOW) begin
            off = int'(reg_num);
        end else if (int'(reg_num) == PC_NUM) begin
            off = PHYS_PC;
        end else if (int'(reg_num) < SPLR_FIRST) begin
            off = ((bank == BK_FIQ) ? PHYS_HI_FIQ : PHYS_HI_USR) + int'(reg_num) - HI_FIRST;
        end else begin
            off = PHYS_SPLR + NUM_SPLR * int'(bank) + int'(reg_num) - SPLR_FIRST;
        end
        idx = PHYS_IDX_W'(off);
    end
endmodule

// File: rtl/status_bank.sv
// Saved-status store: one register per exception mode, read and written
// through the register of the current mode.
// Assumes bank/has_saved come from mode_decode; synchronous active-low reset.
module status_bank
    import bank_pkg::*;
#(
    parameter int STS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_e            bank,
    input  logic             has_saved,
    input  logic             we,
    input  logic [STS_W-1:0] wdata,
    output logic [STS_W-1:0] rdata
);
    localparam int SLOT_W = $clog2(NUM_SAVED);

    logic [NUM_SAVED-1:0][STS_W-1:0] sts;
    logic [SLOT_W-1:0]               slot;

    // Exception banks start at 1, so slot is bank minus one
    assign slot = SLOT_W'(int'(bank) - 1);

    for (genvar i = 0; i < NUM_SAVED; i++) begin : g_sts
        // Hold one mode's saved status; write only when that mode is current
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts[i] <= '0;
            end else if (we && has_saved && int'(slot) == i) begin
                sts[i] <= wdata;
            end
        end
    end

    // Return the current mode's entry, zero for modes without one
    always_comb begin
        rdata = '0;
        if (has_saved) begin
            rdata = sts[slot];
        end
    end

    // R9
    sts_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !has_saved) |=> $stable(sts));
endmodule

// File: rtl/banked_regfile.sv
// Mode-banked general register file: current-mode register, two read ports,
// one write port, a user-bank override and per-mode saved status.
// Assumes synchronous active-low reset; reads are combinational, writes,
// mode loads and status writes take effect at the rising edge.
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [MODE_W-1:0] mode_in,
    output logic [MODE_W-1:0] cur_mode,
    input  logic              user_bank,
    input  logic [REG_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [REG_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sts_wr_en,
    input  logic [STS_W-1:0]  sts_wr_data,
    output logic [STS_W-1:0]  sts_rd_data
);
    localparam int NUM_PORTS = 3;
    localparam int P_RDA = 0;
    localparam int P_RDB = 1;
    localparam int P_WR  = 2;

    logic [MODE_W-1:0]                      mode_q;
    bank_e                                  cur_bank;
    bank_e                                  gpr_bank;
    logic                                   has_saved;
    logic [NUM_PORTS-1:0][REG_W-1:0]        port_sel;
    logic [NUM_PORTS-1:0][PHYS_IDX_W-1:0]   port_idx;
    logic [NUM_PHYS-1:0][DATA_W-1:0]        gpr;

    // Current mode: supervisor after reset, reloaded on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SVC;
        end else if (mode_ld) begin
            mode_q <= mode_in;
        end
    end

    assign cur_mode = mode_q;

    mode_decode u_dec (
        .mode      (mode_q),
        .bank      (cur_bank),
        .has_saved (has_saved)
    );

    // Register ports use the user bank while the override is high
    assign gpr_bank = user_bank ? BK_USR : cur_bank;

    assign port_sel = {wr_sel, rd_b_sel, rd_a_sel};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
        phys_map u_map (
            .reg_num (port_sel[p]),
            .bank    (gpr_bank),
            .idx     (port_idx[p])
        );
    end

    for (genvar i = 0; i < NUM_PHYS; i++) begin : g_gpr
        // One physical entry: cleared on reset, loaded when the write maps here
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gpr[i] <= '0;
            end else if (wr_en && port_idx[P_WR] == PHYS_IDX_W'(i)) begin
                gpr[i] <= wr_data;
            end
        end
    end

    assign rd_a_data = gpr[port_idx[P_RDA]];
    assign rd_b_data = gpr[port_idx[P_RDB]];

    status_bank #(.STS_W(STS_W)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank      (cur_bank),
        .has_saved (has_saved),
        .we        (sts_wr_en),
        .wdata     (sts_wr_data),
        .rdata     (sts_rd_data)
    );

    // R1
    reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cur_mode == MODE_SVC));

    // R9
    sts_user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_USR || cur_mode == MODE_SYS) |-> (sts_rd_data == '0));

    // R6
    sys_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SYS) |-> (cur_bank == BK_USR && !has_saved));

    // R11
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_ld) |=> (rd_a_sel != $past(wr_sel) ||
                                 user_bank != $past(user_bank) ||
                                 rd_a_data == $past(wr_data)));

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ld |=> (cur_mode == $past(mode_in)));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ld = 1'b0;
    logic [4:0]  mode_in = '0;
    logic [4:0]  cur_mode;
    logic        user_bank = 1'b0;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, sts_wr_en = 1'b0;
    logic [31:0] sts_wr_data = '0, sts_rd_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] ref_gpr [48];
    logic [31:0] ref_sts [6];
    logic [4:0]  ref_mode;

    always #10 clk = ~clk;  // 50 MHz

    banked_regfile uut (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_in(mode_in),
        .cur_mode(cur_mode), .user_bank(user_bank),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data)
    );

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic bit legal(logic [4:0] m);
        return m == 5'b10000 || m == 5'b11111 || bank_of(m) != 0;
    endfunction

    function automatic int slot(int b, int r);
        if (r < 8 || r == 15) return r;
        if (b == 1) return 16 + r;
        if (r < 13) return r;
        return 32 + 2 * b + (r - 13);
    endfunction

    function automatic string tag_of(int r, bit ovr, logic [4:0] m);
        if (ovr) return "R10";
        if (r < 8 || r == 15) return "R3";
        if (!legal(m)) return "R7";
        if (m == 5'b11111) return "R6";
        if (bank_of(m) == 1) return "R4";
        return "R5";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: inputs already driven at the falling edge
    task automatic cycle(string tf);
        int b;
        #5;
        b = user_bank ? 0 : bank_of(ref_mode);
        chk((tf != "") ? tf : "R2", {27'd0, cur_mode}, {27'd0, ref_mode});
        chk((tf != "") ? tf : tag_of(rd_a_sel, user_bank, ref_mode),
            rd_a_data, ref_gpr[slot(b, rd_a_sel)]);
        chk((tf != "") ? tf : {"R12/", tag_of(rd_b_sel, user_bank, ref_mode)},
            rd_b_data, ref_gpr[slot(b, rd_b_sel)]);
        chk((tf != "") ? tf : ((bank_of(ref_mode) != 0) ? "R8" : "R9"), sts_rd_data,
            (bank_of(ref_mode) != 0) ? ref_sts[bank_of(ref_mode)] : 32'd0);
        @(posedge clk);
        if (wr_en) ref_gpr[slot(b, wr_sel)] = wr_data;  // old mode (R11)
        if (sts_wr_en && bank_of(ref_mode) != 0) ref_sts[bank_of(ref_mode)] = sts_wr_data;
        if (mode_ld) ref_mode = mode_in;
        @(negedge clk);
    endtask

    task automatic idle();
        mode_ld = 0; wr_en = 0; sts_wr_en = 0; user_bank = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [4:0] legal_modes [7];
        legal_modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
        foreach (ref_gpr[i]) ref_gpr[i] = '0;
        foreach (ref_sts[i]) ref_sts[i] = '0;
        ref_mode = 5'b10011;
        void'($urandom(32'd20240611));
        // Write attempts during reset must be discarded (R1)
        wr_en = 1; wr_sel = 4'd3; wr_data = 32'hDEAD_BEEF;
        sts_wr_en = 1; sts_wr_data = 32'h1234_5678;
        mode_ld = 1; mode_in = 5'b10001;
        repeat (3) @(negedge clk);
        idle();
        rst_n = 1;
        // R1: reset state over all registers and every mode
        for (int m = 0; m < 7; m++) begin
            mode_in = legal_modes[m]; mode_ld = (m != 0);
            if (m == 0) begin
                #5;
                chk("R1", {27'd0, cur_mode}, 32'h13);
                @(negedge clk);
            end else begin
                rd_a_sel = 4'd0; rd_b_sel = 4'd0;
                cycle("R1");
            end
            mode_ld = 0;
            for (int r = 0; r < 16; r += 2) begin
                rd_a_sel = 4'(r); rd_b_sel = 4'(r + 1);
                cycle("R1");
            end
        end
        // R11: write r9 and switch to fast interrupt in the same cycle
        mode_in = 5'b10011; mode_ld = 1; cycle("R2");
        wr_en = 1; wr_sel = 4'd9; wr_data = 32'hA5A5_0009;
        mode_in = 5'b10001; mode_ld = 1; rd_a_sel = 4'd9; rd_b_sel = 4'd9;
        cycle("R11");   // same-cycle read returns old (zero)
        idle();
        cycle("R11");   // fiq r9 still zero; user r9 written
        user_bank = 1; cycle("R10");
        idle();
        // R4 / R5: fiq r13 private, svc r13 private
        wr_en = 1; wr_sel = 4'd13; wr_data = 32'h0F1F_0013; cycle("");
        idle(); mode_in = 5'b10011; mode_ld = 1; rd_a_sel = 4'd13; cycle("");
        idle(); cycle("R5");
        // Random mixed traffic
        for (int k = 0; k < 3000; k++) begin
            mode_ld = ($urandom() % 6) == 0;
            mode_in = (($urandom() % 8) == 0) ? 5'($urandom()) : legal_modes[$urandom() % 7];
            user_bank = ($urandom() % 5) == 0;
            rd_a_sel = 4'($urandom()); rd_b_sel = 4'($urandom());
            wr_en = ($urandom() % 2) == 0;
            wr_sel = (($urandom() % 3) == 0) ? rd_a_sel : 4'($urandom());
            wr_data = $urandom();
            sts_wr_en = ($urandom() % 4) == 0;
            sts_wr_data = $urandom();
            cycle("");
        end
        idle();
        // R9: status write in user mode has no effect anywhere
        mode_in = 5'b10000; mode_ld = 1; cycle("");
        idle(); sts_wr_en = 1; sts_wr_data = 32'hFFFF_FFFF; cycle("R9");
        idle(); for (int m = 1; m < 6; m++) begin
            mode_in = legal_modes[m]; mode_ld = 1; cycle("");
            idle(); cycle("R8");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule